// File: doc/BRIEF.md
# ADC Result Sequencer with Overrun Detection

This block files the results of an external conversion engine. Each time the engine pulses its done strobe, the 10-bit result goes into one of sixteen result registers. A 4-bit conversion counter picks the register. The same write raises that register's conversion-complete flag. If the flag was still set, the write overwrote data nobody read, so a sticky overrun flag is raised.

A sequence starts in one of two ways: a write to the control register, or a pulse on the trigger input. An abort input stops a running sequence. The control register holds the mode bit and the sequence length.

- In non-FIFO mode, each sequence fills the registers from index 0.
- In FIFO mode, the counter and the complete flags carry over from one triggered sequence to the next. This makes the sixteen registers act as a ring buffer.

Software reaches the block through a small read/write register port. Address map:

| Address | Name | Access | Contents |
|---|---|---|---|
| 0x00 to 0x0F | Result | read | One result, zero-extended |
| 0x10 | Control | read/write | bit 0 = FIFO mode, bits 7:4 = sequence length minus one |
| 0x11 | Status | read, write 1 to clear | bit 0 = overrun, bit 1 = sequence done, bit 2 = busy, bits 7:4 = conversion counter |
| 0x12 | Complete flags | read | Bit i is the complete flag of result register i |

All unused read bits return 0.

Top module: `adc_result_seq`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0: results, control, status, and complete flags.
- R2: While busy, a done strobe writes the result into the register the counter selects, sets that register's complete flag, and advances the counter. The counter wraps from 15 to 0. A done strobe while idle changes nothing.
- R3: In non-FIFO mode (control bit 0 = 0), the counter is 0 when a sequence starts. It returns to 0 after the last conversion of the sequence.
- R4: In FIFO mode (control bit 0 = 1), a trigger pulse starts a sequence without moving the counter. The counter also does not return to 0 at the end of a sequence.
- R5: The counter goes to 0 in either mode when the control register is written or when abort is pulsed. Abort also clears busy. Abort takes priority over a start in the same cycle.
- R6: Overrun (status bit 0) sets when a result lands in a register whose complete flag is still set. A read of that same result register in the same cycle counts as reading first, so no overrun is raised.
- R7: Overrun is sticky. It clears only when 1 is written to status bit 0 or when a new sequence starts. A set in the same cycle as a write-1 clear wins.
- R8: A complete flag clears when its result register is read with the read strobe. In non-FIFO mode, all complete flags also clear when a sequence starts. In FIFO mode they are kept across starts.
- R9: A sequence runs for the control length field plus one conversions, from 1 to 16. It then clears busy (status bit 2) and sets sequence-done (status bit 1). Sequence-done clears on a start or on a write of 1 to status bit 1.
- R10: The control register reads back the value written to it, and the read data follows the address map above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_done | input | 1 | One-cycle pulse: a result is ready |
| conv_data | input | 10 | Result from the conversion engine |
| trig | input | 1 | External sequence start pulse |
| abort | input | 1 | Sequence abort pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears a result register's complete flag |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |

## Verification
The block's timing is simple:
- Every effect of a done strobe, trigger, abort or register write is registered. It is visible on the read port in the cycle right after the clock edge that sampled the stimulus.
- Read data is combinational from the address, so inspecting a register has no side effect unless the read strobe is raised.

The bench uses this timing directly:
- It drives each stimulus for exactly one clock.
- It reads the results, status and flags back on the falling edge that follows, with the read strobe low, so the check itself changes nothing.
- The same-cycle corner cases are driven as a single cycle with both strobes high together: a done strobe with a read of the target register, and a done strobe with a write-1 clear.

// File: rtl/adc_result_seq.sv
module adc_result_seq #(
  parameter int DW = 10,
  parameter int AW = 5,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  input  logic          trig,
  input  logic          abort,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata
);
  localparam int NREG = 16;
  localparam int CW   = $clog2(NREG);
  localparam logic [AW-1:0] A_CTRL = AW'(NREG);
  localparam logic [AW-1:0] A_STAT = AW'(NREG + 1);
  localparam logic [AW-1:0] A_FLAG = AW'(NREG + 2);

  logic [DW-1:0]   res [NREG];
  logic [NREG-1:0] ccf;
  logic [CW-1:0]   cnt, pos;
  logic [7:0]      ctrl;
  logic            ovr, done_q, busy;

  wire ctrl_wr  = reg_wr && reg_addr == A_CTRL;
  wire stat_wr  = reg_wr && reg_addr == A_STAT;
  wire res_sel  = reg_addr < AW'(NREG);
  wire fifo_eff = ctrl_wr ? reg_wdata[0] : ctrl[0];
  wire start    = (ctrl_wr || trig) && !abort;
  wire acc      = conv_done && busy && !start && !abort;
  wire last     = pos == ctrl[7:4];
  wire rd_hit   = reg_rd && res_sel && reg_addr[CW-1:0] == cnt;
  wire ovr_set  = acc && ccf[cnt] && !rd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; cnt <= '0; pos <= '0;
      ovr <= 1'b0; done_q <= 1'b0; busy <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= reg_wdata[7:0];

      if (ovr_set) ovr <= 1'b1;
      else if (start || (stat_wr && reg_wdata[0])) ovr <= 1'b0;

      if (abort) begin
        busy <= 1'b0; cnt <= '0; pos <= '0;
      end else if (start) begin
        busy <= 1'b1; pos <= '0; done_q <= 1'b0;
        if (ctrl_wr || !fifo_eff) cnt <= '0;
      end else if (acc) begin
        pos <= pos + 1'b1;
        cnt <= (last && !ctrl[0]) ? '0 : cnt + 1'b1;
        if (last) begin
          busy <= 1'b0; done_q <= 1'b1;
        end
      end

      if (!start && !(acc && last) && stat_wr && reg_wdata[1]) done_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res[i] <= '0; ccf[i] <= 1'b0;
      end else if (acc && cnt == CW'(i)) begin
        res[i] <= conv_data; ccf[i] <= 1'b1;
      end else if ((start && !fifo_eff) ||
                   (reg_rd && reg_addr == AW'(i))) begin
        ccf[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (res_sel) reg_rdata[DW-1:0] = res[reg_addr[CW-1:0]];
    else if (reg_addr == A_CTRL) reg_rdata[7:0] = ctrl;
    else if (reg_addr == A_STAT) reg_rdata[7:0] = {cnt, 1'b0, busy, done_q, ovr};
    else if (reg_addr == A_FLAG) reg_rdata[NREG-1:0] = ccf;
  end

  AST_CTRL_CLR_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !abort |=> cnt == '0); // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy && cnt == '0); // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && busy && !trig && !reg_wr && !abort && !reg_rd && ccf[cnt] |=> ovr); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !trig && !reg_wr |=> ovr); // R7
  AST_CCF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ccf[$past(cnt)]); // R2
  AST_NF_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && last && !ctrl[0] |=> cnt == '0 && done_q && !busy); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !trig && !reg_wr && !abort |=> $stable(cnt)); // R2
endmodule

// File: tb/sim_adc_result_seq.sv
module sim_adc_result_seq;
  logic clk = 0, rst_n = 0;
  logic conv_done = 0, trig = 0, abort = 0, reg_wr = 0, reg_rd = 0;
  logic [9:0] conv_data = '0;
  logic [4:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_result_seq u0 (.clk, .rst_n, .conv_done, .conv_data, .trig, .abort,
                     .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata);

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input logic [4:0] a, input logic [15:0] exp,
                       input logic [15:0] mask, input string req);
    reg_addr = a; #1;
    checks++;
    if ((reg_rdata & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s addr=%0h actual=%h expected=%h", req, a, reg_rdata & mask, exp & mask);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(); reg_wr = 0;
  endtask

  task automatic done(input logic [9:0] d);
    conv_done = 1; conv_data = d; cyc(); conv_done = 0;
  endtask

  task automatic pulse_trig();  trig = 1;  cyc(); trig = 0;  endtask
  task automatic pulse_abort(); abort = 1; cyc(); abort = 0; endtask

  task automatic t_reset();
    check(5'h11, 16'h0, 16'hFFFF, "R1 status");
    check(5'h12, 16'h0, 16'hFFFF, "R1 flags");
    check(5'h10, 16'h0, 16'hFFFF, "R1 ctrl");
    check(5'h07, 16'h0, 16'hFFFF, "R1 result");
  endtask

  task automatic t_nonfifo();
    wr(5'h10, 16'h0030);
    check(5'h10, 16'h0030, 16'hFFFF, "R10 ctrl readback");
    check(5'h11, 16'h0004, 16'hFFFF, "R3 start cnt0 busy");
    for (int i = 0; i < 4; i++) done(10'h200 + 10'(i));
    for (int i = 0; i < 4; i++) check(5'(i), 16'h200 + 16'(i), 16'hFFFF, "R2 result");
    check(5'h12, 16'h000F, 16'hFFFF, "R2 flags");
    check(5'h11, 16'h0002, 16'hFFFF, "R9 R3 end of sequence");
    done(10'h3FF);
    check(5'h12, 16'h000F, 16'hFFFF, "R2 idle done ignored flags");
    check(5'h04, 16'h0000, 16'hFFFF, "R2 idle done ignored result");
  endtask

  task automatic t_read_clear();
    reg_rd = 1; reg_addr = 5'h00; cyc(); reg_rd = 0;
    check(5'h12, 16'h000E, 16'hFFFF, "R8 read clears flag");
    pulse_trig();
    check(5'h12, 16'h0000, 16'hFFFF, "R8 nonfifo start clears flags");
    check(5'h11, 16'h0004, 16'hFFFF, "R9 start clears seq done");
    pulse_abort();
    check(5'h11, 16'h0000, 16'hFFFF, "R5 abort idle");
  endtask

  task automatic t_fifo();
    wr(5'h10, 16'h0031);
    for (int i = 0; i < 4; i++) done(10'h100 + 10'(i));
    check(5'h11, 16'h0042, 16'hFFFF, "R4 fifo end keeps cnt");
    pulse_trig();
    check(5'h11, 16'h0044, 16'hFFFF, "R4 trigger keeps cnt");
    for (int i = 0; i < 4; i++) done(10'h110 + 10'(i));
    check(5'h11, 16'h0082, 16'hFFFF, "R4 fifo continues");
    check(5'h05, 16'h0111, 16'hFFFF, "R4 result 5");
    check(5'h12, 16'h00FF, 16'hFFFF, "R8 fifo keeps flags");
    wr(5'h10, 16'h00F1);
    check(5'h11, 16'h0004, 16'hFFFF, "R5 ctrl write clears cnt in fifo");
    check(5'h12, 16'h00FF, 16'hFFFF, "R8 fifo start keeps flags");
  endtask

  task automatic t_overrun();
    done(10'h050);
    check(5'h11, 16'h0015, 16'hFFFF, "R6 overrun set");
    done(10'h051);
    check(5'h11, 16'h0025, 16'hFFFF, "R7 sticky");
    wr(5'h11, 16'h0001);
    check(5'h11, 16'h0024, 16'hFFFF, "R7 w1c");
    conv_done = 1; conv_data = 10'h052; reg_rd = 1; reg_addr = 5'h02;
    cyc(); conv_done = 0; reg_rd = 0;
    check(5'h11, 16'h0034, 16'hFFFF, "R6 same-cycle read prevents");
    check(5'h02, 16'h0052, 16'hFFFF, "R6 result written");
    check(5'h12, 16'h00FF, 16'hFFFF, "R6 flag re-set");
    conv_done = 1; conv_data = 10'h053; reg_wr = 1; reg_addr = 5'h11; reg_wdata = 16'h0001;
    cyc(); conv_done = 0; reg_wr = 0;
    check(5'h11, 16'h0045, 16'hFFFF, "R7 set wins over clear");
    pulse_trig();
    check(5'h11, 16'h0044, 16'hFFFF, "R7 start clears overrun");
    pulse_abort();
    check(5'h11, 16'h0000, 16'hFFFF, "R5 abort clears cnt");
  endtask

  task automatic t_wrap();
    wr(5'h10, 16'h0071);
    for (int i = 0; i < 8; i++) done(10'h180 + 10'(i));
    check(5'h11, 16'h0082, 16'hF0F6, "R9 eight conversions");
    pulse_trig();
    for (int i = 0; i < 8; i++) done(10'h1C0 + 10'(i));
    check(5'h11, 16'h0002, 16'hF0F6, "R2 wrap 15 to 0");
    check(5'h0F, 16'h01C7, 16'hFFFF, "R2 last register");
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    t_reset();
    t_nonfifo();
    t_read_clear();
    t_fifo();
    t_overrun();
    t_wrap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule